// File: doc/BRIEF.md
# Capture Compare PWM Unit

A single-channel timing unit that works with two external timers: a free-running 16-bit base timer and an 8-bit period timer with two extra fine bits. A 4-bit mode field in its control register picks one of three jobs. In capture mode it copies the base timer into its 16-bit data register when a chosen edge arrives on the input pin. In compare mode it watches for the base timer becoming equal to the data register and then acts on the output pin, raises the interrupt flag, or requests a timer clear and an ADC conversion. In PWM mode it produces a pulse whose 10-bit width is made of the low data byte and two fine bits held in the control register.

Software reaches the unit through a byte-wide register port with three locations: control, data low byte and data high byte. The same 16-bit data register serves as the capture result, the compare reference and, through its low byte, the PWM duty. The interrupt flag stays set until the clear input is pulsed. The timer-clear and ADC-start outputs are single-cycle pulses meant for the neighbouring timer and converter.

Top module: `ccp_unit`

## Requirements
- R1: After reset every register location reads 0, and ccp_out, irq_flag, tmr_clear and adc_go are 0.
- R2: The register port decodes reg_addr 0 as control (bits 5:4 = duty fine bits, bits 3:0 = mode, bits 7:6 always read 0), 1 as data bits 7:0, 2 as data bits 15:8, and 3 reads 0; a write takes effect at the clock edge where reg_we is high, a read is combinational.
- R3: Mode 0100 captures on each falling edge of cap_pin and mode 0101 on each rising edge; after a two-stage synchronizer the capture copies base_tmr into the data register and sets irq_flag, both visible after the third clock edge following the pin change; the opposite edge captures nothing.
- R4: Mode 0110 captures only on every 4th rising edge and mode 0111 only on every 16th.
- R5: Writing a mode value different from the current one clears the edge prescale count, so counting restarts from zero.
- R6: Mode 1000 drives ccp_out high and mode 1001 drives it low on a compare match; both set irq_flag; the effect appears after the clock edge at which base_tmr first equals the data register.
- R7: Mode 1010 sets irq_flag on a match and leaves ccp_out unchanged.
- R8: Mode 1011 on a match sets irq_flag, leaves ccp_out unchanged, and gives a one-cycle tmr_clear pulse together with a one-cycle adc_go pulse that appears only when adc_en is high.
- R9: A match fires once when base_tmr becomes equal to the data register and does not fire again while it stays equal.
- R10: Modes 11xx select PWM: the duty is {data[7:0], control[5:4]}; after the edge where per_start is high ccp_out is high unless the duty is 0, and it goes low after the edge at which {per_cnt, per_fine} equals the duty, so ccp_out is high exactly while the count is below the duty.
- R11: The PWM duty is loaded into a shadow copy only at per_start; a register write made mid-period acts from the next period.
- R12: irq_clr clears irq_flag; when a new capture or match arrives in the same cycle as irq_clr the flag stays set.
- R13: Mode 0000 switches the unit off: ccp_out is low from the second clock edge after the mode is written and stays low while the mode remains 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register location |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| base_tmr | input | 16 | Free-running base timer value |
| per_cnt | input | 8 | Period timer value |
| per_fine | input | 2 | Fine bits below the period timer |
| per_start | input | 1 | One-cycle pulse at the start of each PWM period |
| cap_pin | input | 1 | Asynchronous capture input |
| adc_en | input | 1 | ADC present and enabled |
| irq_clr | input | 1 | Clears the interrupt flag |
| ccp_out | output | 1 | Output pin |
| irq_flag | output | 1 | Interrupt flag |
| tmr_clear | output | 1 | One-cycle base timer clear request |
| adc_go | output | 1 | One-cycle ADC start request |

## Verification
The assertions take for granted that reg_addr, irq_clr and adc_en may change on any cycle, but that the unit is reset before use, so the mode-history properties start from a known off state. The pulse properties rely only on the match being an entry into equality, so they hold whatever sequence base_tmr follows. The stimulus holds base_tmr steady around each capture and match so the expected data value is unambiguous, writes the compare reference while in the flag-only mode so partial byte writes cannot move the pin, and raises per_start only when the period count is zero.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

    // register locations
    localparam logic [1:0] LOC_CTRL = 2'd0;
    localparam logic [1:0] LOC_DLO  = 2'd1;
    localparam logic [1:0] LOC_DHI  = 2'd2;

    // mode codes
    localparam logic [3:0] MD_OFF      = 4'b0000;
    localparam logic [3:0] MD_CAP_FALL = 4'b0100;
    localparam logic [3:0] MD_CAP_RISE = 4'b0101;
    localparam logic [3:0] MD_CAP_R4   = 4'b0110;
    localparam logic [3:0] MD_CAP_R16  = 4'b0111;
    localparam logic [3:0] MD_CMP_HI   = 4'b1000;
    localparam logic [3:0] MD_CMP_LO   = 4'b1001;
    localparam logic [3:0] MD_CMP_FLAG = 4'b1010;
    localparam logic [3:0] MD_CMP_EVT  = 4'b1011;

    function automatic logic mode_is_cap(input logic [3:0] m);
        return m[3:2] == 2'b01;
    endfunction

    function automatic logic mode_is_cmp(input logic [3:0] m);
        return m[3:2] == 2'b10;
    endfunction

    function automatic logic mode_is_pwm(input logic [3:0] m);
        return m[3:2] == 2'b11;
    endfunction

endpackage

// File: rtl/ccp_cap_edge.sv
// Synchronizes the capture pin and turns selected edges into capture events,
// with an optional edge prescaler.
module ccp_cap_edge import ccp_pkg::*; #(
    parameter int SYNC_N = 2,
    parameter int PRE_LO = 4,
    parameter int PRE_HI = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [3:0] mode,
    input  logic       cnt_clr,
    output logic       cap_evt
);
    localparam int PRE_W = $clog2(PRE_HI);

    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              last;
        logic [PRE_W-1:0]  cnt;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d    = st_q;
        cap_evt = 1'b0;
        st_d.sync = {st_q.sync[SYNC_N-2:0], pin};
        st_d.last = st_q.sync[SYNC_N-1];
        rise = st_q.sync[SYNC_N-1] & ~st_q.last;
        fall = ~st_q.sync[SYNC_N-1] & st_q.last;

        case (mode)
            MD_CAP_FALL: cap_evt = fall;
            MD_CAP_RISE: cap_evt = rise;
            MD_CAP_R4: begin
                if (rise) begin
                    if (st_q.cnt >= PRE_W'(PRE_LO - 1)) begin
                        cap_evt  = 1'b1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            MD_CAP_R16: begin
                if (rise) begin
                    if (st_q.cnt == PRE_W'(PRE_HI - 1)) begin
                        cap_evt  = 1'b1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: st_d.cnt = '0;
        endcase

        if (cnt_clr) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ccp_cmp_match.sv
// Reports a match only on the cycle the timer enters equality.
module ccp_cmp_match #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tmr,
    input  logic [TW-1:0] ref_val,
    output logic          hit
);
    typedef struct packed {
        logic eq;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    logic    eq_now;

    always_comb begin
        eq_now  = (tmr == ref_val);
        st_d    = st_q;
        st_d.eq = eq_now;
        hit     = eq_now & ~st_q.eq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ccp_pwm_core.sv
// PWM level generator with a duty shadow loaded at each period start.
module ccp_pwm_core #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic [DW-1:0] count,
    input  logic [DW-1:0] duty,
    output logic          level
);
    typedef struct packed {
        logic [DW-1:0] shadow;
        logic          lvl;
    } pwm_st_t;

    pwm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (start) begin
            st_d.shadow = duty;
            st_d.lvl    = (duty != '0);
        end else if (count == st_q.shadow) begin
            st_d.lvl = 1'b0;
        end
        level = st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ccp_unit.sv
// Capture / compare / PWM channel: register file, mode decode, flag and pulses.
module ccp_unit import ccp_pkg::*; #(
    parameter int BW     = 8,
    parameter int FW     = 2,
    parameter int SYNC_N = 2,
    parameter int PRE_LO = 4,
    parameter int PRE_HI = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [BW-1:0]   reg_wdata,
    output logic [BW-1:0]   reg_rdata,
    input  logic [2*BW-1:0] base_tmr,
    input  logic [BW-1:0]   per_cnt,
    input  logic [FW-1:0]   per_fine,
    input  logic            per_start,
    input  logic            cap_pin,
    input  logic            adc_en,
    input  logic            irq_clr,
    output logic            ccp_out,
    output logic            irq_flag,
    output logic            tmr_clear,
    output logic            adc_go
);
    localparam int TW = 2 * BW;
    localparam int DW = BW + FW;
    localparam int CW = FW + 4;

    typedef struct packed {
        logic [CW-1:0] ctrl;
        logic [TW-1:0] dat;
        logic          cmp_out;
        logic          flag;
        logic          tmr_rst;
        logic          adc_req;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic [3:0]    mode_q;
    logic [FW-1:0] duty_fine;
    logic          mode_chg;
    logic          cap_evt;
    logic          cmp_hit;
    logic          pwm_lvl;
    logic          flag_set;

    assign mode_q    = st_q.ctrl[3:0];
    assign duty_fine = st_q.ctrl[CW-1:4];
    assign mode_chg  = reg_we && (reg_addr == LOC_CTRL) && (reg_wdata[3:0] != mode_q);

    ccp_cap_edge #(
        .SYNC_N (SYNC_N),
        .PRE_LO (PRE_LO),
        .PRE_HI (PRE_HI)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (cap_pin),
        .mode    (mode_q),
        .cnt_clr (mode_chg),
        .cap_evt (cap_evt)
    );

    ccp_cmp_match #(
        .TW (TW)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmr     (base_tmr),
        .ref_val (st_q.dat),
        .hit     (cmp_hit)
    );

    ccp_pwm_core #(
        .DW (DW)
    ) u_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mode_is_pwm(mode_q)),
        .start (per_start),
        .count ({per_cnt, per_fine}),
        .duty  ({st_q.dat[BW-1:0], duty_fine}),
        .level (pwm_lvl)
    );

    always_comb begin
        st_d         = st_q;
        st_d.tmr_rst = 1'b0;
        st_d.adc_req = 1'b0;
        flag_set     = 1'b0;

        // register writes
        if (reg_we) begin
            case (reg_addr)
                LOC_CTRL: st_d.ctrl           = reg_wdata[CW-1:0];
                LOC_DLO:  st_d.dat[BW-1:0]    = reg_wdata;
                LOC_DHI:  st_d.dat[TW-1:BW]   = reg_wdata;
                default:  ;
            endcase
        end

        if (mode_q == MD_OFF) begin
            st_d.cmp_out = 1'b0;
        end

        // capture overrides a same-cycle data write
        if (mode_is_cap(mode_q) && cap_evt) begin
            st_d.dat = base_tmr;
            flag_set = 1'b1;
        end

        if (mode_is_cmp(mode_q) && cmp_hit) begin
            flag_set = 1'b1;
            case (mode_q)
                MD_CMP_HI: st_d.cmp_out = 1'b1;
                MD_CMP_LO: st_d.cmp_out = 1'b0;
                MD_CMP_EVT: begin
                    st_d.tmr_rst = 1'b1;
                    st_d.adc_req = adc_en;
                end
                default: ;
            endcase
        end

        if (flag_set) begin
            st_d.flag = 1'b1;
        end else if (irq_clr) begin
            st_d.flag = 1'b0;
        end

        // read mux
        case (reg_addr)
            LOC_CTRL: reg_rdata = {{(BW-CW){1'b0}}, st_q.ctrl};
            LOC_DLO:  reg_rdata = st_q.dat[BW-1:0];
            LOC_DHI:  reg_rdata = st_q.dat[TW-1:BW];
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ccp_out   = mode_is_pwm(mode_q) ? pwm_lvl : st_q.cmp_out;
    assign irq_flag  = st_q.flag;
    assign tmr_clear = st_q.tmr_rst;
    assign adc_go    = st_q.adc_req;

endmodule

// File: rtl/ccp_unit_chk.sv
module ccp_unit_chk #(
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    reg_addr,
    input logic [BW-1:0] reg_rdata,
    input logic [3:0]    mode_q,
    input logic          irq_clr,
    input logic          ccp_out,
    input logic          irq_flag,
    input logic          tmr_clear,
    input logic          adc_go
);

    AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[BW-1:6] == '0)); // R2

    AST_EVT_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clear |=> !tmr_clear); // R8

    AST_ADC_WITH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        adc_go |-> tmr_clear); // R8

    AST_EVT_FROM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_clear |-> ($past(mode_q) == 4'b1011)); // R8

    AST_FLAG_DROP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(irq_clr)); // R12

    AST_OFF_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == 4'b0000) && ($past(mode_q) == 4'b0000)) |-> !ccp_out); // R13

endmodule

bind ccp_unit ccp_unit_chk #(.BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .mode_q    (mode_q),
    .irq_clr   (irq_clr),
    .ccp_out   (ccp_out),
    .irq_flag  (irq_flag),
    .tmr_clear (tmr_clear),
    .adc_go    (adc_go)
);

// File: tb/sim_ccp_unit.sv
`timescale 1ns/1ps
module sim_ccp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [15:0] base_tmr = 16'd0;
    logic [7:0]  per_cnt = 8'd0;
    logic [1:0]  per_fine = 2'd0;
    logic        per_start = 1'b0;
    logic        cap_pin = 1'b0;
    logic        adc_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic        ccp_out, irq_flag, tmr_clear, adc_go;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ccp_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .base_tmr(base_tmr),
        .per_cnt(per_cnt), .per_fine(per_fine), .per_start(per_start),
        .cap_pin(cap_pin), .adc_en(adc_en), .irq_clr(irq_clr),
        .ccp_out(ccp_out), .irq_flag(irq_flag), .tmr_clear(tmr_clear), .adc_go(adc_go)
    );

    function automatic logic pwm_expect(input int c, input int duty);
        return c < duty;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic clr_flag();
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
    endtask

    task automatic pin_pulse();
        cap_pin = 1'b1;
        repeat (4) tick();
        cap_pin = 1'b0;
        repeat (4) tick();
    endtask

    // load the reference in flag-only mode, arm the target mode, then match
    task automatic cmp_trial(input logic [3:0] md, input logic [15:0] val, input bit clr_at_hit);
        wr(2'd0, 8'h0A);
        wr(2'd1, val[7:0]);
        wr(2'd2, val[15:8]);
        base_tmr = ~val;
        tick();
        wr(2'd0, {4'h0, md});
        clr_flag();
        base_tmr = val;
        irq_clr = clr_at_hit;
        tick();
        irq_clr = 1'b0;
    endtask

    task automatic run_period(input string tag, input int duty, input bit mid_wr, input logic [7:0] mid_lo);
        int bad = 0;
        for (int c = 0; c < 1024; c++) begin
            per_start = (c == 0);
            per_cnt   = c[9:2];
            per_fine  = c[1:0];
            if (mid_wr && c == 100) begin
                reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = mid_lo;
            end
            tick();
            reg_we = 1'b0;
            if (ccp_out !== pwm_expect(c, duty)) bad++;
        end
        per_start = 1'b0;
        chk(tag, bad, 0);
    endtask

    task automatic pwm_set(input int duty);
        wr(2'd1, duty[9:2]);
        wr(2'd0, {2'b00, duty[1:0], 4'b1100});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd_chk("R1 ctrl", 2'd0, 8'h00);
        rd_chk("R1 dlo", 2'd1, 8'h00);
        rd_chk("R1 dhi", 2'd2, 8'h00);
        chk("R1 out", ccp_out, 0);
        chk("R1 flag", irq_flag, 0);
        chk("R1 pulses", {tmr_clear, adc_go}, 0);

        // R2 register port
        wr(2'd0, 8'hFF);
        rd_chk("R2 ctrl top bits", 2'd0, 8'h3F);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hA5);
        wr(2'd2, 8'h5A);
        rd_chk("R2 dlo", 2'd1, 8'hA5);
        rd_chk("R2 dhi", 2'd2, 8'h5A);
        rd_chk("R2 loc3", 2'd3, 8'h00);

        // R3 rising capture
        base_tmr = 16'h1234;
        wr(2'd0, 8'h05);
        cap_pin = 1'b1;
        repeat (2) tick();
        chk("R3 not yet", irq_flag, 0);
        tick();
        chk("R3 rise flag", irq_flag, 1);
        rd_chk("R3 rise lo", 2'd1, 8'h34);
        rd_chk("R3 rise hi", 2'd2, 8'h12);
        base_tmr = 16'hBEEF;
        clr_flag();
        cap_pin = 1'b0;
        repeat (4) tick();
        chk("R3 fall ignored in rise mode", irq_flag, 0);

        // R3 falling capture
        wr(2'd0, 8'h04);
        base_tmr = 16'h0F0E;
        cap_pin = 1'b1;
        repeat (4) tick();
        chk("R3 rise ignored in fall mode", irq_flag, 0);
        rd_chk("R3 data kept", 2'd1, 8'h34);
        cap_pin = 1'b0;
        repeat (4) tick();
        chk("R3 fall flag", irq_flag, 1);
        rd_chk("R3 fall lo", 2'd1, 8'h0E);
        rd_chk("R3 fall hi", 2'd2, 8'h0F);

        // R3 random single-edge captures
        for (int i = 0; i < 6; i++) begin
            logic [15:0] tv = 16'($urandom);
            logic fmode = 1'($urandom);
            wr(2'd0, fmode ? 8'h04 : 8'h05);
            clr_flag();
            base_tmr = tv;
            pin_pulse();
            chk("R3 random flag", irq_flag, 1);
            rd_chk("R3 random lo", 2'd1, tv[7:0]);
            rd_chk("R3 random hi", 2'd2, tv[15:8]);
        end

        // R4 prescale by 4
        wr(2'd0, 8'h06);
        clr_flag();
        base_tmr = 16'h4444;
        repeat (3) pin_pulse();
        chk("R4 div4 after 3", irq_flag, 0);
        pin_pulse();
        chk("R4 div4 after 4", irq_flag, 1);
        rd_chk("R4 div4 data", 2'd1, 8'h44);

        // R4 prescale by 16
        wr(2'd0, 8'h07);
        clr_flag();
        base_tmr = 16'h1616;
        repeat (15) pin_pulse();
        chk("R4 div16 after 15", irq_flag, 0);
        pin_pulse();
        chk("R4 div16 after 16", irq_flag, 1);

        // R5 mode change restarts the count
        wr(2'd0, 8'h06);
        clr_flag();
        repeat (2) pin_pulse();
        wr(2'd0, 8'h07);
        wr(2'd0, 8'h06);
        repeat (3) pin_pulse();
        chk("R5 count restarted", irq_flag, 0);
        pin_pulse();
        chk("R5 fourth after restart", irq_flag, 1);

        // R13 off mode
        wr(2'd0, 8'h00);
        tick();
        chk("R13 off low", ccp_out, 0);

        // R6 set on match
        cmp_trial(4'b1000, 16'h2345, 1'b0);
        chk("R6 set pin", ccp_out, 1);
        chk("R6 set flag", irq_flag, 1);

        // R9 no retrigger while equal
        clr_flag();
        repeat (4) tick();
        chk("R9 held equal no flag", irq_flag, 0);
        base_tmr = 16'h2346;
        tick();
        base_tmr = 16'h2345;
        tick();
        chk("R9 re-entry flag", irq_flag, 1);

        // R7 flag only
        cmp_trial(4'b1010, 16'h7777, 1'b0);
        chk("R7 pin unchanged", ccp_out, 1);
        chk("R7 flag", irq_flag, 1);

        // R6 clear on match
        cmp_trial(4'b1001, 16'h0100, 1'b0);
        chk("R6 clr pin", ccp_out, 0);
        chk("R6 clr flag", irq_flag, 1);

        // R6 random
        for (int i = 0; i < 16; i++) begin
            logic [15:0] v = 16'($urandom);
            logic hi = 1'($urandom);
            cmp_trial(hi ? 4'b1000 : 4'b1001, v, 1'b0);
            chk("R6 random pin", ccp_out, hi);
            chk("R6 random flag", irq_flag, 1);
        end

        // R8 special event
        cmp_trial(4'b1000, 16'h0033, 1'b0);
        adc_en = 1'b1;
        cmp_trial(4'b1011, 16'h5555, 1'b0);
        chk("R8 clear pulse", tmr_clear, 1);
        chk("R8 adc pulse", adc_go, 1);
        chk("R8 pin unchanged", ccp_out, 1);
        tick();
        chk("R8 pulses one cycle", {tmr_clear, adc_go}, 0);
        chk("R8 flag", irq_flag, 1);
        adc_en = 1'b0;
        cmp_trial(4'b1011, 16'h6666, 1'b0);
        chk("R8 clear without adc", tmr_clear, 1);
        chk("R8 adc gated", adc_go, 0);

        // R12 set wins over clear, then clear
        cmp_trial(4'b1010, 16'h9999, 1'b1);
        chk("R12 set wins", irq_flag, 1);
        clr_flag();
        chk("R12 cleared", irq_flag, 0);

        // R13 off drops a high pin
        cmp_trial(4'b1000, 16'hABCD, 1'b0);
        chk("R13 pin high before off", ccp_out, 1);
        wr(2'd0, 8'h00);
        tick();
        chk("R13 off drops pin", ccp_out, 0);
        rd_chk("R13 ctrl reads off", 2'd0, 8'h00);

        // R10 PWM duties
        pwm_set(0);
        run_period("R10 duty 0", 0, 1'b0, 8'h00);
        pwm_set(1);
        run_period("R10 duty 1", 1, 1'b0, 8'h00);
        pwm_set(515);
        run_period("R10 duty 515", 515, 1'b0, 8'h00);
        pwm_set(1023);
        run_period("R10 duty 1023", 1023, 1'b0, 8'h00);
        for (int i = 0; i < 4; i++) begin
            int d = int'($urandom % 1024);
            pwm_set(d);
            run_period("R10 random duty", d, 1'b0, 8'h00);
        end

        // R11 mid-period write deferred
        pwm_set(768);
        run_period("R11 old duty kept", 768, 1'b1, 8'h20);
        run_period("R11 new duty next period", 128, 1'b0, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule